// File: doc/BRIEF.md
# Parse Node Redirect Unit

This block picks the next fetch address of a packet parser engine whenever a parse node finishes or a parse check fails. A parse node ends with a stop strobe that carries a kind. The kind says whether to jump through the Next register, to leave the parser by its success target, to enter a sub-protocol walk, or to resume the parent node. A separate exception strobe carries an error code. It sends control to the failure target and records the code. No conditional branch is ever evaluated here: all control flow comes from these two strobes and the values held in the target registers.

The target registers are loaded through one write port. The values may come from a table lookup result or from any other parser operation. A four-entry return stack holds the resume addresses of parent nodes while a nested walk, such as a TLV loop, runs. The output is a one-cycle redirect pulse with its target address, plus the current exit code.

Top module: `prs_redirect_unit`

## Requirements
- R1: After reset, redir_vld and exit_code are 0, all target registers hold 0, and the return stack is empty.
- R2: A stop of kind JUMP (stop_kind=0) gives redir_vld in the next cycle with redir_tgt equal to the Next value held before that clock edge. A Next write in the same cycle as the stop is not seen by that stop.
- R3: A write with wr_en=1 loads wr_data into the register chosen by wr_sel: 0 Next, 1 success target, 2 failure target, 3 exit code (low EXIT_W bits). The exit code is visible on exit_code in the next cycle.
- R4: A stop of kind EXIT (stop_kind=1) redirects to the success target.
- R5: An exception redirects to the failure target in the next cycle, and exit_code takes exc_code in that same cycle.
- R6: When an exception and a stop arrive in the same cycle, the exception is taken and the stop has no effect, including on the return stack.
- R7: When an exception and an exit-code write arrive in the same cycle, exit_code takes the exception code.
- R8: redir_vld is high for exactly one cycle. Stop and exception strobes presented while redir_vld is high are ignored.
- R9: A stop of kind CALL (stop_kind=2) pushes stop_ret and redirects to Next. A stop of kind RET (stop_kind=3) pops the most recently pushed address and redirects to it, in last-in first-out order.
- R10: A CALL while 4 entries are held raises an exception to the failure target with exit code OVF_CODE (default 16'h00F1) and leaves the stack unchanged.
- R11: A RET with an empty stack raises an exception to the failure target with exit code UNF_CODE (default 16'h00F2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Target register write strobe |
| wr_sel | input | 2 | Register select: 0 Next, 1 success, 2 failure, 3 exit code |
| wr_data | input | ADDR_W | Write data |
| stop_vld | input | 1 | Parse node stop strobe |
| stop_kind | input | 2 | 0 JUMP, 1 EXIT, 2 CALL, 3 RET |
| stop_ret | input | ADDR_W | Resume address pushed by a CALL |
| exc_vld | input | 1 | Parse check failure strobe |
| exc_code | input | EXIT_W | Failure condition code |
| redir_vld | output | 1 | One-cycle redirect pulse |
| redir_tgt | output | ADDR_W | Redirect target address |
| exit_code | output | EXIT_W | Latched exit code |

## Verification
A node's stop and a failed check can land on the same clock edge. An exception can also meet a software write to the exit code register. The bench drives an exception together with a CALL stop and then issues a RET. The RET must report underflow, which shows the CALL left no entry behind. The bench also drives an exception together with an exit-code write and checks that exit_code shows the exception code. A third test drives an exception during the redirect cycle and confirms that neither the redirect nor the exit code responds.

// File: rtl/prs_redirect_pkg.sv
package prs_redirect_pkg;
  typedef enum logic [1:0] {
    STOP_JUMP = 2'd0,
    STOP_EXIT = 2'd1,
    STOP_CALL = 2'd2,
    STOP_RET  = 2'd3
  } stop_kind_e;

  typedef enum logic [1:0] {
    SEL_NEXT = 2'd0,
    SEL_OKAY = 2'd1,
    SEL_FAIL = 2'd2,
    SEL_EXIT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prs_redir_regs.sv
module prs_redir_regs
  import prs_redirect_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int EXIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              fault_we,
  input  logic [EXIT_W-1:0] fault_code,
  output logic [ADDR_W-1:0] next_q,
  output logic [ADDR_W-1:0] okay_q,
  output logic [ADDR_W-1:0] fail_q,
  output logic [EXIT_W-1:0] exit_q
);
  logic [ADDR_W-1:0] next_d, okay_d, fail_d;
  logic [EXIT_W-1:0] exit_d;

  always_comb begin
    next_d = next_q;
    okay_d = okay_q;
    fail_d = fail_q;
    exit_d = exit_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_NEXT: next_d = wr_data;
        SEL_OKAY: okay_d = wr_data;
        SEL_FAIL: fail_d = wr_data;
        SEL_EXIT: exit_d = wr_data[EXIT_W-1:0];
      endcase
    end
    if (fault_we) exit_d = fault_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      okay_q <= '0;
      fail_q <= '0;
      exit_q <= '0;
    end else begin
      next_q <= next_d;
      okay_q <= okay_d;
      fail_q <= fail_d;
      exit_q <= exit_d;
    end
  end

  AST_FAULT_CODE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we |=> exit_q == $past(fault_code)); // R7
endmodule

// File: rtl/prs_redir_stack.sv
module prs_redir_stack #(
  parameter int ADDR_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] top_data,
  output logic              full,
  output logic              empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  top_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign top_data = mem_q[top_idx];

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full)       cnt_d = cnt_q + 1'b1;
    else if (pop && !empty)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push && !full && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[i] <= '0;
      else if (slot_en) mem_q[i] <= push_data;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R11
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R9
endmodule

// File: rtl/prs_redir_arb.sv
module prs_redir_arb
  import prs_redirect_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int EXIT_W = 16,
  parameter logic [EXIT_W-1:0] OVF_CODE = 16'h00F1,
  parameter logic [EXIT_W-1:0] UNF_CODE = 16'h00F2
) (
  input  logic              busy,
  input  logic              stop_vld,
  input  stop_kind_e        stop_kind,
  input  logic              exc_vld,
  input  logic [EXIT_W-1:0] exc_code,
  input  logic              stk_full,
  input  logic              stk_empty,
  input  logic [ADDR_W-1:0] stk_top,
  input  logic [ADDR_W-1:0] next_q,
  input  logic [ADDR_W-1:0] okay_q,
  input  logic [ADDR_W-1:0] fail_q,
  output logic              push,
  output logic              pop,
  output logic              fault_we,
  output logic [EXIT_W-1:0] fault_code,
  output logic              redir_d,
  output logic [ADDR_W-1:0] tgt_d
);
  logic exc_take, stop_take, ovf, unf;

  assign exc_take  = !busy && exc_vld;
  assign stop_take = !busy && stop_vld && !exc_vld;
  assign ovf  = stop_take && (stop_kind == STOP_CALL) && stk_full;
  assign unf  = stop_take && (stop_kind == STOP_RET)  && stk_empty;
  assign push = stop_take && (stop_kind == STOP_CALL) && !stk_full;
  assign pop  = stop_take && (stop_kind == STOP_RET)  && !stk_empty;
  assign fault_we = exc_take || ovf || unf;
  assign redir_d  = exc_take || stop_take;

  always_comb begin
    if (exc_take)  fault_code = exc_code;
    else if (ovf)  fault_code = OVF_CODE;
    else           fault_code = UNF_CODE;
  end

  always_comb begin
    if (fault_we) tgt_d = fail_q;
    else begin
      unique case (stop_kind)
        STOP_JUMP: tgt_d = next_q;
        STOP_EXIT: tgt_d = okay_q;
        STOP_CALL: tgt_d = next_q;
        STOP_RET:  tgt_d = stk_top;
      endcase
    end
  end
endmodule

// File: rtl/prs_redirect_unit.sv
module prs_redirect_unit
  import prs_redirect_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int EXIT_W = 16,
  parameter int DEPTH  = 4,
  parameter logic [EXIT_W-1:0] OVF_CODE = 16'h00F1,
  parameter logic [EXIT_W-1:0] UNF_CODE = 16'h00F2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              stop_vld,
  input  logic [1:0]        stop_kind,
  input  logic [ADDR_W-1:0] stop_ret,
  input  logic              exc_vld,
  input  logic [EXIT_W-1:0] exc_code,
  output logic              redir_vld,
  output logic [ADDR_W-1:0] redir_tgt,
  output logic [EXIT_W-1:0] exit_code
);
  logic              rst_s1, rst_sn;
  logic [ADDR_W-1:0] next_q, okay_q, fail_q, stk_top, tgt_d;
  logic              push, pop, stk_full, stk_empty, fault_we, redir_d;
  logic [EXIT_W-1:0] fault_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  prs_redir_regs #(.ADDR_W(ADDR_W), .EXIT_W(EXIT_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_sel(reg_sel_e'(wr_sel)),
    .wr_data(wr_data), .fault_we(fault_we), .fault_code(fault_code),
    .next_q(next_q), .okay_q(okay_q), .fail_q(fail_q), .exit_q(exit_code)
  );

  prs_redir_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_sn), .push(push), .pop(pop), .push_data(stop_ret),
    .top_data(stk_top), .full(stk_full), .empty(stk_empty)
  );

  prs_redir_arb #(.ADDR_W(ADDR_W), .EXIT_W(EXIT_W),
                  .OVF_CODE(OVF_CODE), .UNF_CODE(UNF_CODE)) u_arb (
    .busy(redir_vld), .stop_vld(stop_vld), .stop_kind(stop_kind_e'(stop_kind)),
    .exc_vld(exc_vld), .exc_code(exc_code), .stk_full(stk_full),
    .stk_empty(stk_empty), .stk_top(stk_top), .next_q(next_q), .okay_q(okay_q),
    .fail_q(fail_q), .push(push), .pop(pop), .fault_we(fault_we),
    .fault_code(fault_code), .redir_d(redir_d), .tgt_d(tgt_d)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      redir_vld <= 1'b0;
      redir_tgt <= '0;
    end else begin
      redir_vld <= redir_d;
      if (redir_d) redir_tgt <= tgt_d;
    end
  end

  AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    redir_vld |=> !redir_vld); // R8
  AST_EXC_TO_FAIL: assert property (@(posedge clk) disable iff (!rst_sn)
    (exc_vld && !redir_vld) |=> (redir_vld && redir_tgt == $past(fail_q)
                                 && exit_code == $past(exc_code))); // R5
  AST_JUMP_TO_NEXT: assert property (@(posedge clk) disable iff (!rst_sn)
    (stop_vld && !exc_vld && !redir_vld && stop_kind == 2'd0)
      |=> (redir_vld && redir_tgt == $past(next_q))); // R2
  AST_EXIT_TO_OKAY: assert property (@(posedge clk) disable iff (!rst_sn)
    (stop_vld && !exc_vld && !redir_vld && stop_kind == 2'd1)
      |=> (redir_vld && redir_tgt == $past(okay_q))); // R4
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_sn)
    redir_vld |=> $stable(exit_code) || $past(wr_en)); // R8
endmodule

// File: tb/prs_redirect_unit_bench.sv
`timescale 1ns/1ps
module prs_redirect_unit_bench;
  localparam int AW = 64;
  localparam int EW = 16;
  localparam logic [EW-1:0] OVF = 16'h00F1;
  localparam logic [EW-1:0] UNF = 16'h00F2;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, stop_vld, exc_vld;
  logic [1:0] wr_sel, stop_kind;
  logic [AW-1:0] wr_data, stop_ret;
  logic [EW-1:0] exc_code;
  logic redir_vld;
  logic [AW-1:0] redir_tgt;
  logic [EW-1:0] exit_code;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  prs_redirect_unit u_prs_redirect_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stop_vld(stop_vld), .stop_kind(stop_kind), .stop_ret(stop_ret),
    .exc_vld(exc_vld), .exc_code(exc_code), .redir_vld(redir_vld),
    .redir_tgt(redir_tgt), .exit_code(exit_code)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; stop_vld = 0; exc_vld = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); idle();
  endtask

  // stop strobe for one cycle, check redirect pulse then its fall
  task automatic stop(input string req, input logic [1:0] kind, input logic [AW-1:0] ret,
                      input logic [AW-1:0] exp_tgt);
    stop_vld = 1; stop_kind = kind; stop_ret = ret;
    @(negedge clk); idle();
    chk(req, redir_vld, 1); chk(req, redir_tgt, exp_tgt);
    @(negedge clk);
    chk({req, " R8"}, redir_vld, 0);
  endtask

  task automatic t_reset();
    chk("R1 redir", redir_vld, 0); chk("R1 exit", exit_code, 0);
    stop("R1 next zero", 2'd0, 0, 0);
    stop("R1 empty stack R11", 2'd3, 0, 0);
    chk("R1 underflow code R11", exit_code, UNF);
  endtask

  task automatic t_writes();
    wr(2'd0, 64'h1000); wr(2'd1, 64'h2000); wr(2'd2, 64'h3000); wr(2'd3, 64'hFFFF_0055);
    chk("R3 exit write", exit_code, 16'h0055);
    stop("R2 jump", 2'd0, 0, 64'h1000);
    stop("R4 exit", 2'd1, 0, 64'h2000);
  endtask

  task automatic t_next_same_cycle();
    wr_en = 1; wr_sel = 2'd0; wr_data = 64'h1100;
    stop("R2 old next", 2'd0, 0, 64'h1000);
    stop("R2 new next R3", 2'd0, 0, 64'h1100);
  endtask

  task automatic t_exc();
    exc_vld = 1; exc_code = 16'h0021;
    @(negedge clk); idle();
    chk("R5 redir", redir_vld, 1); chk("R5 tgt", redir_tgt, 64'h3000);
    chk("R5 code", exit_code, 16'h0021);
    @(negedge clk);
  endtask

  task automatic t_exc_vs_stop();
    exc_vld = 1; exc_code = 16'h0022;
    stop("R6 exc wins", 2'd2, 64'hAAA, 64'h3000);
    chk("R6 code", exit_code, 16'h0022);
    stop("R6 no push", 2'd3, 0, 64'h3000);
    chk("R6 no push code", exit_code, UNF);
  endtask

  task automatic t_exc_vs_wr();
    exc_vld = 1; exc_code = 16'h0023; wr_en = 1; wr_sel = 2'd3; wr_data = 64'h77;
    @(negedge clk); idle();
    chk("R7 code", exit_code, 16'h0023);
    @(negedge clk);
  endtask

  task automatic t_busy();
    stop_vld = 1; stop_kind = 2'd0;
    @(negedge clk); idle();
    exc_vld = 1; exc_code = 16'h0024; stop_vld = 1; stop_kind = 2'd1;
    @(negedge clk); idle();
    chk("R8 ignored redir", redir_vld, 0);
    chk("R8 ignored code", exit_code, 16'h0023);
  endtask

  task automatic t_stack();
    for (int i = 0; i < 4; i++) stop("R9 call", 2'd2, 64'hA0 + i, 64'h1100);
    stop("R10 overflow", 2'd2, 64'hBB, 64'h3000);
    chk("R10 code", exit_code, OVF);
    for (int i = 3; i >= 0; i--) stop("R9 ret lifo", 2'd3, 0, 64'hA0 + i);
    stop("R11 underflow", 2'd3, 0, 64'h3000);
    chk("R11 code", exit_code, UNF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(); wr_sel = 0; wr_data = 0; stop_kind = 0; stop_ret = 0; exc_code = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_writes();
    t_next_same_cycle();
    t_exc();
    t_exc_vs_stop();
    t_exc_vs_wr();
    t_busy();
    t_stack();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule